// File: doc/BRIEF.md
# Two-Level Alternating Master Arbiter

This block decides which of three requesters may drive a single shared bus-master engine. The three requesters are the PCI target path, the DMA channel that moves data from the system bus out to PCI, and the DMA channel that moves data from PCI in to the system bus. Each requester raises a request line. The arbiter answers with a registered one-hot grant, and it keeps that grant until the owner pulses done.

Priority rotates at two levels. At the upper level, the PCI requester and the DMA group as a whole take turns. At the lower level, the two DMA channels take turns with each other. With this scheme each DMA channel gets a slot in every second DMA turn, so DMA traffic as a group reaches the bus often, and PCI is never locked out for longer than one DMA transfer. When a requester is the only one asking, it is granted at once, whichever side holds the turn.

Top module: `hier_master_arb`

## Requirements
- R1: While rst_ni is low, gnt_o is 3'b000. The reset is asynchronous.
- R2: gnt_o is always either one-hot or zero. Bit 0 grants the PCI requester, bit 1 the outbound DMA channel and bit 2 the inbound DMA channel. It is driven from a register.
- R3: When gnt_o is zero and at least one req_i bit is set at a clock edge, gnt_o becomes non-zero at that edge and grants only a requester that was asking. A requester that is the only one asking is granted even when the turn belongs to the other side.
- R4: Upper level: when PCI (req_i[0]) and at least one DMA channel are requesting together, the side that was not given the previous grant wins.
- R5: Lower level: when both DMA channels (req_i[1], req_i[2]) are requesting and the DMA group wins, the channel that was not given the previous DMA grant wins.
- R6: A turn flag changes only when a grant is issued. The upper flag changes on every grant. The lower flag changes only on DMA grants. Idle cycles leave both flags unchanged.
- R7: Once issued, a grant stays unchanged until done_i is sampled high. Dropping the owner's request or raising other requests does not move it.
- R8: A clock edge with done_i high and a grant active clears gnt_o to zero. A new grant can then be issued at the next edge.
- R9: After reset, the upper level favours PCI and the lower level favours the outbound DMA channel. With all three requesting continuously, the grant order is PCI, outbound, PCI, inbound, PCI, outbound.
- R10: done_i sampled while gnt_o is zero has no effect. With no request, gnt_o stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Requests: bit0 PCI, bit1 outbound DMA, bit2 inbound DMA |
| done_i | input | 1 | Owner pulses high to end its grant |
| gnt_o | output | 3 | Registered one-hot grant, same bit order as req_i |

## Verification
The turn flags cannot be seen at the ports. A wrong flag therefore shows up only when two sides contend: the loser of the previous contest wins again, and the wrong grant bit appears at the edge that issues the grant, one cycle after the previous owner's done. The tests set up a turn, separate it from the next contest with idle cycles and ignored done pulses, and then check that the pending turn is still honoured. A hold or release fault shows up as soon as it happens: the grant moves while it is being held, or it is still non-zero in the cycle after done.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_REQ = 3;
  localparam int unsigned REQ_PCI = 0;
  localparam int unsigned REQ_OUT = 1;
  localparam int unsigned REQ_IN  = 2;
  typedef logic [NUM_REQ-1:0] vec_t;
endpackage

// File: rtl/arb_pair_pick.sv
// Two-way alternating pick; turn flag updates only on upd_i.
module arb_pair_pick #(
  parameter bit RST_PREF_A = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_a_i,
  input  logic req_b_i,
  input  logic upd_i,
  output logic pick_a_o,
  output logic pick_b_o
);
  logic pref_a_q;

  assign pick_a_o = req_a_i & (pref_a_q | ~req_b_i);
  assign pick_b_o = req_b_i & (~pref_a_q | ~req_a_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pref_a_q <= RST_PREF_A;
    else if (upd_i) pref_a_q <= pick_b_o; // loser gets the next turn
  end
endmodule

// File: rtl/arb_gnt_reg.sv
module arb_gnt_reg
  import arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  vec_t nxt_i,
  input  logic done_i,
  output vec_t gnt_o,
  output logic idle_o
);
  vec_t gnt_q;

  assign idle_o = (gnt_q == '0);
  assign gnt_o  = gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gnt_q <= '0;
    else if (idle_o)            gnt_q <= nxt_i;
    else if (done_i)            gnt_q <= '0;
  end
endmodule

// File: rtl/hier_master_arb.sv
module hier_master_arb
  import arb_pkg::*;
#(
  parameter bit RST_PREF_PCI = 1'b1,
  parameter bit RST_PREF_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               done_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  logic dma_any, idle, issue;
  logic pick_pci, pick_dma, pick_out, pick_in;
  vec_t nxt;

  assign dma_any = req_i[REQ_OUT] | req_i[REQ_IN];
  assign issue   = idle & (|req_i);

  // upper level: PCI vs DMA group
  arb_pair_pick #(.RST_PREF_A(RST_PREF_PCI)) i_lvl_top (
    .clk_i, .rst_ni,
    .req_a_i (req_i[REQ_PCI]),
    .req_b_i (dma_any),
    .upd_i   (issue),
    .pick_a_o(pick_pci),
    .pick_b_o(pick_dma)
  );

  // lower level: outbound vs inbound DMA
  arb_pair_pick #(.RST_PREF_A(RST_PREF_OUT)) i_lvl_dma (
    .clk_i, .rst_ni,
    .req_a_i (req_i[REQ_OUT]),
    .req_b_i (req_i[REQ_IN]),
    .upd_i   (issue & pick_dma),
    .pick_a_o(pick_out),
    .pick_b_o(pick_in)
  );

  always_comb begin
    nxt          = '0;
    nxt[REQ_PCI] = pick_pci;
    nxt[REQ_OUT] = pick_dma & pick_out;
    nxt[REQ_IN]  = pick_dma & pick_in;
  end

  arb_gnt_reg i_gnt (
    .clk_i, .rst_ni,
    .nxt_i (nxt),
    .done_i,
    .gnt_o,
    .idle_o(idle)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] req_i,
  input logic       done_i,
  input logic [2:0] gnt_o
);
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r3_serve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i != 3'b000) |=> (gnt_o != 3'b000));

  a_r3_only_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000) |=> ((gnt_o & $past(req_i)) == gnt_o));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != 3'b000 && !done_i) |=> $stable(gnt_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != 3'b000 && done_i) |=> (gnt_o == 3'b000));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i == 3'b000) |=> (gnt_o == 3'b000));
endmodule

bind hier_master_arb arb_checker i_arb_checker (
  .clk_i, .rst_ni, .req_i, .done_i, .gnt_o
);

// File: tb/test_hier_master_arb.sv
module test_hier_master_arb;
  localparam time CLK_PERIOD = 10;
  localparam logic [2:0] G_P = 3'b001, G_O = 3'b010, G_I = 3'b100, G_0 = 3'b000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req_i = '0;
  logic       done_i = 1'b0;
  logic [2:0] gnt_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hier_master_arb i_hier_master_arb (.clk_i, .rst_ni, .req_i, .done_i, .gnt_o);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input logic [2:0] exp, input string tag);
    n_chk++;
    if (gnt_o !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt_o=%b expected=%b", tag, gnt_o, exp);
    end
  endtask

  task automatic do_reset();
    req_i = '0; done_i = 1'b0;
    #1 rst_ni = 1'b0; #2;
    check(G_0, "R1 async reset");
    step();
    check(G_0, "R1 held in reset");
    rst_ni = 1'b1;
    step();
  endtask

  // expect a grant at the next edge, then release with done
  task automatic grant_release(input logic [2:0] exp, input string tag);
    step();
    check(exp, tag);
    done_i = 1'b1;
    step();
    check(G_0, "R8 cleared after done");
    done_i = 1'b0;
  endtask

  task automatic t_rotation();
    do_reset();
    req_i = 3'b111;
    grant_release(G_P, "R9 first PCI");
    grant_release(G_O, "R9 then outbound");
    grant_release(G_P, "R4 PCI again");
    grant_release(G_I, "R5 inbound turn");
    grant_release(G_P, "R4 PCI again");
    grant_release(G_O, "R5 outbound turn");
  endtask

  task automatic t_dma_only();
    do_reset();
    req_i = 3'b110;
    grant_release(G_O, "R5 out first");
    grant_release(G_I, "R5 in second");
    grant_release(G_O, "R5 out third");
    req_i = 3'b111;
    grant_release(G_P, "R4 PCI after DMA");
  endtask

  task automatic t_sole();
    do_reset();
    req_i = 3'b100;
    grant_release(G_I, "R3 sole inbound");
    grant_release(G_I, "R3 sole inbound repeat");
    req_i = 3'b001;
    grant_release(G_P, "R3 sole PCI");
    grant_release(G_P, "R3 sole PCI repeat");
  endtask

  task automatic t_turn_kept();
    do_reset();
    req_i = 3'b001;
    grant_release(G_P, "R3 PCI alone");
    req_i = 3'b000;
    for (int k = 0; k < 4; k++) begin
      done_i = k[0];
      step();
      check(G_0, "R10 idle done ignored");
    end
    done_i = 1'b0;
    req_i = 3'b111;
    grant_release(G_O, "R6 turn kept across idle");
    grant_release(G_P, "R6 PCI next");
  endtask

  task automatic t_hold();
    do_reset();
    req_i = 3'b001;
    step();
    check(G_P, "R7 initial grant");
    req_i = 3'b110;
    for (int k = 0; k < 5; k++) begin
      step();
      check(G_P, "R7 held without done");
    end
    done_i = 1'b1;
    step();
    check(G_0, "R8 release");
    done_i = 1'b0;
    step();
    check(G_O, "R8 regrant next edge");
    #1 rst_ni = 1'b0; #2;
    check(G_0, "R1 reset clears active grant");
    rst_ni = 1'b1;
  endtask

  initial begin
    fork
      begin
        t_rotation();
        t_dma_only();
        t_sole();
        t_turn_kept();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule